// File: doc/BRIEF.md
# Cycle-Based Servo Pulse Generator

This block drives the control line of one hobby servo. Each output frame is built from whole cycles. First comes a configurable number of cycles in which the line stays high. Then comes one modulated cycle, in which the line stays high for a number of steps set by an 8-bit angle input. The frame ends with a configurable number of cycles in which the line stays low. The frame then repeats.

Cycle timing comes from a slow, free-running reference input that runs alongside the system clock. The block synchronises this input into the system clock domain and counts its rising edges. Each cycle is 256 reference periods long, so a 256 kHz reference gives 1 ms cycles. The frame period is therefore (HIGH_CYCLE + LOW_CYCLE + 1) cycles. An enable input holds the output low and returns the block to the start of a frame. When enable rises again, the frame starts over cleanly.

Top module: `servo_frame_pwm`

## Requirements
- R1: While `rst` is high, and on the clock after it, `servo` is low and the block sits at step 0 of frame cycle 0.
- R2: A cycle lasts exactly 256 rising edges of `ref_in`, and a frame lasts (HIGH_CYCLE + LOW_CYCLE + 1) cycles. With a steady reference of period P system clocks, successive rising edges of `servo` are (HIGH_CYCLE + LOW_CYCLE + 1) * 256 * P clocks apart.
- R3: Frame cycles 0 to HIGH_CYCLE-1 keep `servo` high for all of their length. The output pulse of a frame is one contiguous high run that starts at the frame start.
- R4: In the modulated cycle (index HIGH_CYCLE), `servo` is high while the step count within the cycle, from 0 to 255, is below the captured angle. The high time per frame is therefore (HIGH_CYCLE * 256 + angle) reference periods. An angle of 0 adds nothing, and an angle of 255 adds 255 periods.
- R5: When `en` is low, `servo` is low on the next clock and both counters are held at the frame start. On the first clock with `en` high again, the block starts a fresh frame with its first cycle, and `servo` is high one clock later when HIGH_CYCLE > 0.
- R6: The angle is captured when the modulated cycle begins, and it is also tracked while disabled. A change of `angle` during a frame affects only the next frame.
- R7: HIGH_CYCLE may be 0. In that case the frame begins directly with the modulated cycle, and the high time is angle reference periods.
- R8: The cycles after the modulated cycle (LOW_CYCLE of them, LOW_CYCLE >= 1) keep `servo` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Free-running cycle-timing reference, asynchronous to `clk` |
| en | input | 1 | Run enable; low forces the output low and restarts the frame |
| angle | input | 8 | Modulated-cycle high length, in reference periods |
| servo | output | 1 | Servo control line |

## Verification
The assertions assume three things about the reference. It is much slower than `clk`. It is steady enough that each rising edge yields exactly one detect pulse. Its high and low phases each last at least two system clocks. They also take the parameters as legal, with LOW_CYCLE of at least one. The stimulus uses a reference with a period of exactly four system clocks and a 50 % duty cycle, so a cycle is 1024 clocks. Because the synchroniser lag is constant, frame lengths and pulse widths can be predicted to the clock. The stimulus changes `angle` and `en` only at falling clock edges. It measures only frames that start after the first full frame following enable, which avoids the unknown phase of the first reference edge.

// File: rtl/servo_frame_pwm.sv
module servo_frame_pwm #(
  parameter int HIGH_CYCLE = 1,
  parameter int LOW_CYCLE  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       en,
  input  logic [7:0] angle,
  output logic       servo
);
  localparam int NCYC = HIGH_CYCLE + LOW_CYCLE + 1;
  localparam int CW   = (NCYC > 2) ? $clog2(NCYC) : 1;
  localparam logic [CW-1:0] MOD_IDX  = CW'(HIGH_CYCLE);
  localparam logic [CW-1:0] LAST_IDX = CW'(NCYC - 1);

  logic [2:0]    ref_sync;
  logic [7:0]    pos;
  logic [CW-1:0] cyc;
  logic [7:0]    ang_q;
  logic          tick, wrap, in_high, in_mod;
  logic [CW-1:0] cyc_nxt;

  always_ff @(posedge clk) begin
    if (rst) ref_sync <= '0;
    else     ref_sync <= {ref_sync[1:0], ref_in};
  end

  assign tick    = ref_sync[1] & ~ref_sync[2];
  assign wrap    = tick & (pos == 8'hff);
  assign cyc_nxt = (cyc == LAST_IDX) ? '0 : cyc + 1'b1;
  assign in_mod  = (cyc == MOD_IDX);

  generate
    if (HIGH_CYCLE == 0) begin : g_no_high
      assign in_high = 1'b0;
    end else begin : g_high
      assign in_high = (cyc < MOD_IDX);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos   <= '0;
      cyc   <= '0;
      ang_q <= angle;
    end else if (tick) begin
      pos <= pos + 8'd1;
      if (wrap) begin
        cyc <= cyc_nxt;
        if (cyc_nxt == MOD_IDX) ang_q <= angle;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) servo <= 1'b0;
    else     servo <= en & (in_high | (in_mod & (pos < ang_q)));
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |=> (!servo && pos == 8'd0 && cyc == '0));

  a_r2_step_count: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (pos == 8'($past(pos) + 8'd1)));

  a_r2_cycle_range: assert property (@(posedge clk) disable iff (rst) cyc <= LAST_IDX);

  a_r3_high_cycle: assert property (@(posedge clk) disable iff (rst)
    (en && in_high) |=> servo);

  a_r5_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!servo && pos == 8'd0 && cyc == '0));

  a_r6_angle_held: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> $stable(ang_q));

  a_r8_low_cycle: assert property (@(posedge clk) disable iff (rst)
    (cyc > MOD_IDX) |=> !servo);
endmodule

// File: tb/servo_frame_pwm_test.sv
`timescale 1ns/1ps
module servo_frame_pwm_test;
  logic clk = 0, rst = 1, ref_in = 0, en = 0;
  logic [7:0] angle = 0, angle0 = 0;
  logic servo, servo_h0;
  logic sel = 0;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;
  always #10  ref_in = ~ref_in;

  servo_frame_pwm #(.HIGH_CYCLE(1), .LOW_CYCLE(2)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .en(en), .angle(angle), .servo(servo));
  servo_frame_pwm #(.HIGH_CYCLE(0), .LOW_CYCLE(1)) uut_h0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .en(en), .angle(angle0), .servo(servo_h0));

  wire mon = sel ? servo_h0 : servo;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int hi, output int per);
    hi = 0; per = 0;
    @(negedge clk);
    while (mon) @(negedge clk);
    while (!mon) @(negedge clk);
    while (mon) begin hi++; @(negedge clk); end
    per = hi;
    while (!mon) begin per++; @(negedge clk); end
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check("R1 servo low in reset", servo, 0);
    check("R1 h0 servo low in reset", servo_h0, 0);
    rst = 0;
    @(negedge clk);
    check("R1 servo low after reset, disabled", servo, 0);
  endtask

  task automatic t_frame(input logic [7:0] a);
    int hi, per;
    angle = a; sel = 0;
    measure(hi, per);
    measure(hi, per);
    check($sformatf("R4 high time angle %0d", a), hi, (256 + a) * 4);
    check($sformatf("R2 frame period angle %0d", a), per, 4 * 256 * 4);
  endtask

  task automatic t_disable;
    en = 0;
    @(negedge clk);
    check("R5 servo low one clock after en falls", servo, 0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (servo) begin check("R5 servo stays low while disabled", 1, 0); break; end
    end
    check("R5 disabled window ended low", servo, 0);
    en = 1;
    @(negedge clk);
    check("R5 frame restarts high after enable", servo, 1);
  endtask

  task automatic t_midchange;
    int hi, lo, n;
    angle = 8'd200; sel = 0;
    int_dummy_frames();
    @(negedge clk);
    while (servo) @(negedge clk);
    while (!servo) @(negedge clk);
    hi = 0;
    while (servo) begin
      hi++;
      if (hi == 1100) angle = 8'd10;
      @(negedge clk);
    end
    check("R6 mid-frame change keeps captured angle", hi, (256 + 200) * 4);
    lo = 0;
    while (!servo) begin lo++; @(negedge clk); end
    n = 0;
    while (servo) begin n++; @(negedge clk); end
    check("R6 new angle applies next frame", n, (256 + 10) * 4);
    check("R8 low part of frame", lo, 4 * 256 * 4 - (256 + 200) * 4);
  endtask

  task automatic int_dummy_frames;
    int hi, per;
    measure(hi, per);
  endtask

  task automatic t_no_high;
    int hi, per;
    angle0 = 8'd100; sel = 1;
    measure(hi, per);
    measure(hi, per);
    check("R7 zero high cycles: high time = angle", hi, 100 * 4);
    check("R7 zero high cycles: frame period", per, 2 * 256 * 4);
    sel = 0;
  endtask

  initial begin
    #950000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    t_reset();
    angle0 = 8'd100;
    en = 1;
    @(negedge clk);
    check("R5 first cycle high after enable", servo, 1);
    t_frame(8'd128);
    t_frame(8'd0);
    t_frame(8'd255);
    t_frame(8'd37);
    t_disable();
    t_midchange();
    t_no_high();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule